// File: doc/BRIEF.md
# Circular Buffer Address Updater

This block computes the post-increment pointer for circular-buffer addressing. It adds a signed 32-bit offset to the current pointer. It then folds the sum back into a buffer window with at most one correction of plus or minus the buffer length. The window comes from a modifier word and has one of two forms:

- **Explicit-base window.** The window begins at a separately supplied start address. It is used when the modifier carries a zero size exponent and a length of at least four.
- **Legacy aligned window.** Otherwise the window is a power-of-two aligned region found by masking low pointer bits.

A select input switches the result to a bit-reversed form of the pointer, used for FFT-style addressing. In that form the low 16 address bits swap order and the upper bits pass through. The result is registered, so it appears one clock after the inputs. A parameter can remove that register.

Top module: `cbuf_addr_unit`

## Requirements
- R1: The size exponent K is the signed 4-bit field modifier_i[27:24]. The length is modifier_i[16:0], sign-extended to 32 bits.
- R2: When K equals 0 and the signed length is at least 4, the window start is base_i and the window end is base_i plus the length.
- R3: In every other case the window start is ptr_i with its low K+2 bits cleared. When K+2 is zero or negative, no bits are cleared. The window end is that start ORed with the length.
- R4: The sum is ptr_i plus offset_i, modulo 2^32. If the sum is unsigned greater than or equal to the window end, the result is the sum minus the length.
- R5: If the sum is below the window end but unsigned less than the window start, the result is the sum plus the length.
- R6: A sum from the window start up to one below the window end is returned unchanged.
- R7: With brev_sel_i = 1, the result is ptr_i with bits 15:0 in reversed order (bit 0 to bit 15) and bits 31:16 unchanged. offset_i, modifier_i and base_i have no effect.
- R8: addr_o takes the result one rising clk edge after the inputs are applied. While rst_n is low, addr_o is 0.
- R9: Modifier bits 31:28 and 23:17 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| ptr_i | input | 32 | Current pointer |
| offset_i | input | 32 | Signed increment |
| modifier_i | input | 32 | Carries the size exponent and the buffer length |
| base_i | input | 32 | Start address used by the explicit-base window |
| brev_sel_i | input | 1 | 0: circular result, 1: bit-reversed pointer |
| addr_o | output | 32 | Registered updated address |

## Verification
The wrap arithmetic is tried with sums that land at exactly the window end, at one below it, at exactly the window start and just below it. These cases separate the inclusive upper test from the exclusive lower test and show that only one correction is applied. Window selection is tried in several ways:

- A length of exactly four, with a base that is not aligned to the window.
- A length of three.
- Positive and negative exponents.
- A negative length that only gives the stated result when sign extension is correct.

Each of these splits the explicit path from the aligned path. Modifier words with the unrelated fields set, and bit-reverse vectors with asymmetric low halves, confirm which inputs the result depends on.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

   typedef enum logic {
      SEL_CIRC = 1'b0,
      SEL_BREV = 1'b1
   } addr_sel_e;

   typedef enum logic {
      WIN_ALIGNED  = 1'b0,
      WIN_EXPLICIT = 1'b1
   } win_mode_e;

endpackage

// File: rtl/cbuf_field_decode.sv
module cbuf_field_decode #(
   parameter int AW    = 32,
   parameter int K_W   = 4,
   parameter int K_LSB = 24,
   parameter int LEN_W = 17
) (
   input  logic [AW-1:0]  modifier_i,
   output logic [K_W-1:0] k_o,
   output logic [AW-1:0]  len_o
);
   localparam int EXT_W = AW - LEN_W;

   logic [LEN_W-1:0] len_raw;

   assign k_o     = modifier_i[K_LSB +: K_W];
   assign len_raw = modifier_i[LEN_W-1:0];

   generate
      if (EXT_W > 0) begin : g_ext
         assign len_o = {{EXT_W{len_raw[LEN_W-1]}}, len_raw};
      end else begin : g_noext
         assign len_o = len_raw;
      end
   endgenerate

   logic unused_mod_bits;
   assign unused_mod_bits = ^modifier_i;

endmodule

// File: rtl/cbuf_window.sv
module cbuf_window
   import cbuf_pkg::*;
#(
   parameter int AW      = 32,
   parameter int K_W     = 4,
   parameter int MIN_LEN = 4
) (
   input  logic [AW-1:0]  ptr_i,
   input  logic [AW-1:0]  base_i,
   input  logic [K_W-1:0] k_i,
   input  logic [AW-1:0]  len_i,
   output win_mode_e      mode_o,
   output logic [AW-1:0]  start_o,
   output logic [AW-1:0]  end_o
);
   localparam int ALIGN_BIAS = 2;

   logic [AW-1:0] align_mask;
   logic [AW-1:0] aligned_start;
   int            mask_bits;

   always_comb begin
      mask_bits = int'($signed(k_i)) + ALIGN_BIAS;
      for (int i = 0; i < AW; i++) begin
         align_mask[i] = (i < mask_bits);
      end
   end

   assign aligned_start = ptr_i & ~align_mask;

   always_comb begin
      if ((k_i == '0) && ($signed(len_i) >= MIN_LEN)) begin
         mode_o  = WIN_EXPLICIT;
         start_o = base_i;
         end_o   = base_i + len_i;
      end else begin
         mode_o  = WIN_ALIGNED;
         start_o = aligned_start;
         end_o   = aligned_start | len_i;
      end
   end

endmodule

// File: rtl/cbuf_wrap.sv
module cbuf_wrap #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] ptr_i,
   input  logic [AW-1:0] offset_i,
   input  logic [AW-1:0] len_i,
   input  logic [AW-1:0] start_i,
   input  logic [AW-1:0] end_i,
   output logic [AW-1:0] sum_o,
   output logic [AW-1:0] addr_o
);
   logic above_end;
   logic below_start;

   assign sum_o       = ptr_i + offset_i;
   assign above_end   = (sum_o >= end_i);
   assign below_start = (sum_o < start_i);

   always_comb begin
      if (above_end) begin
         addr_o = sum_o - len_i;
      end else if (below_start) begin
         addr_o = sum_o + len_i;
      end else begin
         addr_o = sum_o;
      end
   end

endmodule

// File: rtl/cbuf_bitrev.sv
module cbuf_bitrev #(
   parameter int AW     = 32,
   parameter int BREV_W = 16
) (
   input  logic [AW-1:0] addr_i,
   output logic [AW-1:0] addr_o
);
   genvar g;
   generate
      for (g = 0; g < BREV_W; g++) begin : g_swap
         assign addr_o[g] = addr_i[BREV_W-1-g];
      end
      if (AW > BREV_W) begin : g_keep_upper
         assign addr_o[AW-1:BREV_W] = addr_i[AW-1:BREV_W];
      end
   endgenerate

endmodule

// File: rtl/cbuf_out_stage.sv
module cbuf_out_stage #(
   parameter int AW      = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] d_i,
   output logic [AW-1:0] q_o
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q_o <= '0;
            end else begin
               q_o <= d_i;
            end
         end
      end else begin : g_comb
         assign q_o = d_i;
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
      end
   endgenerate

endmodule

// File: rtl/cbuf_addr_unit.sv
module cbuf_addr_unit
   import cbuf_pkg::*;
#(
   parameter int AW      = 32,
   parameter int K_W     = 4,
   parameter int K_LSB   = 24,
   parameter int LEN_W   = 17,
   parameter int BREV_W  = 16,
   parameter int MIN_LEN = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [31:0]   ptr_i,
   input  logic [31:0]   offset_i,
   input  logic [31:0]   modifier_i,
   input  logic [31:0]   base_i,
   input  logic          brev_sel_i,
   output logic [31:0]   addr_o
);
   localparam int K_TOP = K_LSB + K_W;

   generate
      if (AW != 32) begin : g_bad_aw
         $error("cbuf_addr_unit: AW must match the 32-bit port width");
      end
      if (LEN_W > AW) begin : g_bad_len
         $error("cbuf_addr_unit: LEN_W exceeds AW");
      end
      if (K_TOP > AW || K_LSB < LEN_W) begin : g_bad_k
         $error("cbuf_addr_unit: K field must sit above the length field inside AW");
      end
      if (BREV_W < 1 || BREV_W > AW) begin : g_bad_brev
         $error("cbuf_addr_unit: BREV_W out of range");
      end
   endgenerate

   logic [K_W-1:0] k_w;
   logic [AW-1:0]  len_w;
   logic [AW-1:0]  start_w;
   logic [AW-1:0]  end_w;
   logic [AW-1:0]  sum_w;
   logic [AW-1:0]  wrap_w;
   logic [AW-1:0]  brev_w;
   logic [AW-1:0]  next_w;
   win_mode_e      mode_w;
   logic           explicit_w;

   cbuf_field_decode #(
      .AW(AW), .K_W(K_W), .K_LSB(K_LSB), .LEN_W(LEN_W)
   ) u_decode (
      .modifier_i (modifier_i),
      .k_o        (k_w),
      .len_o      (len_w)
   );

   cbuf_window #(
      .AW(AW), .K_W(K_W), .MIN_LEN(MIN_LEN)
   ) u_window (
      .ptr_i   (ptr_i),
      .base_i  (base_i),
      .k_i     (k_w),
      .len_i   (len_w),
      .mode_o  (mode_w),
      .start_o (start_w),
      .end_o   (end_w)
   );

   assign explicit_w = (mode_w == WIN_EXPLICIT);

   cbuf_wrap #(
      .AW(AW)
   ) u_wrap (
      .ptr_i    (ptr_i),
      .offset_i (offset_i),
      .len_i    (len_w),
      .start_i  (start_w),
      .end_i    (end_w),
      .sum_o    (sum_w),
      .addr_o   (wrap_w)
   );

   cbuf_bitrev #(
      .AW(AW), .BREV_W(BREV_W)
   ) u_bitrev (
      .addr_i (ptr_i),
      .addr_o (brev_w)
   );

   assign next_w = (addr_sel_e'(brev_sel_i) == SEL_BREV) ? brev_w : wrap_w;

   cbuf_out_stage #(
      .AW(AW), .REG_OUT(REG_OUT)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (next_w),
      .q_o   (addr_o)
   );

endmodule

// File: rtl/cbuf_addr_unit_chk.sv
module cbuf_addr_unit_chk #(
   parameter int AW      = 32,
   parameter int K_W     = 4,
   parameter int K_LSB   = 24,
   parameter int BREV_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] ptr_i,
   input logic [AW-1:0] modifier_i,
   input logic [AW-1:0] base_i,
   input logic          brev_sel_i,
   input logic [AW-1:0] addr_o,
   input logic [AW-1:0] sum_w,
   input logic [AW-1:0] len_w,
   input logic [AW-1:0] start_w,
   input logic [AW-1:0] end_w,
   input logic          explicit_w
);

   // R1: the explicit window is only chosen with a zero exponent field
   p_kfield_r1: assert property (@(posedge clk) disable iff (!rst_n)
      explicit_w |-> (modifier_i[K_LSB +: K_W] == '0));

   // R2: the explicit window spans base_i to base_i plus the length
   p_explicit_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
      explicit_w |-> ((start_w == base_i) && (end_w == base_i + len_w)));

   // R3: the aligned start only clears pointer bits and the end covers the length bits
   p_aligned_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !explicit_w |-> (((start_w & ~ptr_i) == '0) && ((end_w & len_w) == len_w)));

   generate
      if (REG_OUT) begin : g_seq
         // R4: a sum at or above the end loses one length
         p_top_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!brev_sel_i && (sum_w >= end_w)) |=> (addr_o == $past(sum_w - len_w)));

         // R5: a sum below the start gains one length
         p_bottom_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!brev_sel_i && (sum_w < end_w) && (sum_w < start_w))
               |=> (addr_o == $past(sum_w + len_w)));

         // R6: a sum inside the window passes unchanged
         p_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!brev_sel_i && (sum_w < end_w) && (sum_w >= start_w))
               |=> (addr_o == $past(sum_w)));

         // R7: bit-reverse keeps the upper bits and swaps the end bits
         p_brev_r7: assert property (@(posedge clk) disable iff (!rst_n)
            brev_sel_i |=> ((addr_o[AW-1:BREV_W] == $past(ptr_i[AW-1:BREV_W]))
                            && (addr_o[0] == $past(ptr_i[BREV_W-1]))
                            && (addr_o[BREV_W-1] == $past(ptr_i[0]))));

         // R8: a reset cycle leaves addr_o at zero
         p_reset_clear_r8: assert property (@(posedge clk)
            !rst_n |=> (addr_o == '0));
      end
   endgenerate

endmodule

bind cbuf_addr_unit cbuf_addr_unit_chk #(
   .AW(AW), .K_W(K_W), .K_LSB(K_LSB), .BREV_W(BREV_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ptr_i      (ptr_i),
   .modifier_i (modifier_i),
   .base_i     (base_i),
   .brev_sel_i (brev_sel_i),
   .addr_o     (addr_o),
   .sum_w      (sum_w),
   .len_w      (len_w),
   .start_w    (start_w),
   .end_w      (end_w),
   .explicit_w (explicit_w)
);

// File: tb/cbuf_addr_unit_tb.sv
module cbuf_addr_unit_tb;

   typedef struct packed {
      logic [31:0] ptr;
      logic [31:0] off;
      logic [31:0] modw;
      logic [31:0] base;
      logic        sel;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NVEC = 17;

   localparam vec_t VECS [NVEC] = '{
      // R2: explicit window, in range
      '{32'h0000_1000, 32'h0000_0004, 32'h0000_0040, 32'h0000_1000, 1'b0, 32'h0000_1004, 8'd2},
      // R4: above end
      '{32'h0000_103C, 32'h0000_0008, 32'h0000_0040, 32'h0000_1000, 1'b0, 32'h0000_1004, 8'd4},
      // R4: exactly at end
      '{32'h0000_103C, 32'h0000_0004, 32'h0000_0040, 32'h0000_1000, 1'b0, 32'h0000_1000, 8'd4},
      // R6: one below end
      '{32'h0000_103C, 32'h0000_0003, 32'h0000_0040, 32'h0000_1000, 1'b0, 32'h0000_103F, 8'd6},
      // R5: below start
      '{32'h0000_1004, 32'hFFFF_FFF8, 32'h0000_0040, 32'h0000_1000, 1'b0, 32'h0000_103C, 8'd5},
      // R6: exactly at start
      '{32'h0000_1004, 32'hFFFF_FFFC, 32'h0000_0040, 32'h0000_1000, 1'b0, 32'h0000_1000, 8'd6},
      // R3: length 3 forces the aligned window, base ignored
      '{32'h0000_2001, 32'h0000_0002, 32'h0000_0003, 32'h0000_9999, 1'b0, 32'h0000_2000, 8'd3},
      // R3: K=3 aligned window, top wrap
      '{32'h0000_5012, 32'h0000_0004, 32'h0300_0014, 32'h0000_0000, 1'b0, 32'h0000_5002, 8'd3},
      // R3: K=3 aligned window, bottom wrap
      '{32'h0000_5002, 32'hFFFF_FFFC, 32'h0300_0014, 32'h0000_0000, 1'b0, 32'h0000_5012, 8'd3},
      // R1: negative K=-2 clears no bits
      '{32'h0000_7000, 32'h0000_0018, 32'h0E00_0010, 32'h0000_0000, 1'b0, 32'h0000_7008, 8'd1},
      // R1: negative length is sign-extended
      '{32'h0000_0100, 32'hFFFF_FFF8, 32'h0001_FFF0, 32'h0000_0000, 1'b0, 32'h0000_00E8, 8'd1},
      // R9: unrelated modifier bits set
      '{32'h0000_103C, 32'h0000_0008, 32'hF0FE_0040, 32'h0000_1000, 1'b0, 32'h0000_1004, 8'd9},
      // R2: unaligned base
      '{32'h0000_1330, 32'h0000_0010, 32'h0000_0100, 32'h0000_1234, 1'b0, 32'h0000_1240, 8'd2},
      // R7: bit reverse, low bit moves to bit 15
      '{32'hABCD_0001, 32'h0000_0055, 32'h0300_0014, 32'h0000_0000, 1'b1, 32'hABCD_8000, 8'd7},
      // R7: bit reverse, mixed pattern
      '{32'h1234_1234, 32'hFFFF_0000, 32'h0000_0040, 32'h0000_1000, 1'b1, 32'h1234_2C48, 8'd7},
      // R3: K=7 window of 512
      '{32'h0000_0A10, 32'h0000_00F8, 32'h0700_0100, 32'h0000_0000, 1'b0, 32'h0000_0A08, 8'd3},
      // R2: length exactly 4 selects explicit window
      '{32'h0000_0043, 32'h0000_0001, 32'h0000_0004, 32'h0000_0041, 1'b0, 32'h0000_0044, 8'd2}
   };

   logic        clk;
   logic        rst_n;
   logic [31:0] ptr_i;
   logic [31:0] offset_i;
   logic [31:0] modifier_i;
   logic [31:0] base_i;
   logic        brev_sel_i;
   logic [31:0] addr_o;

   int checks;
   int failures;
   int cycles;
   bit done;

   cbuf_addr_unit u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ptr_i      (ptr_i),
      .offset_i   (offset_i),
      .modifier_i (modifier_i),
      .base_i     (base_i),
      .brev_sel_i (brev_sel_i),
      .addr_o     (addr_o)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!done && cycles > 5000) begin
         failures = failures + 1;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      ptr_i      = v.ptr;
      offset_i   = v.off;
      modifier_i = v.modw;
      base_i     = v.base;
      brev_sel_i = v.sel;
   endtask

   initial begin
      checks = 0; failures = 0; cycles = 0; done = 1'b0;
      rst_n = 1'b0;
      ptr_i = '0; offset_i = '0; modifier_i = '0; base_i = '0; brev_sel_i = 1'b0;
      drive(VECS[1]);
      repeat (3) @(negedge clk);
      // R8: output held at zero in reset
      check("R8 reset", addr_o, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         drive(VECS[i]);
         @(negedge clk);
         check($sformatf("R%0d vec%0d", VECS[i].req, i), addr_o, VECS[i].exp);
      end

      // R8: latency, new inputs do not show before the next edge
      @(negedge clk);
      drive(VECS[0]);
      @(negedge clk);
      drive(VECS[2]);
      #2;
      check("R8 latency hold", addr_o, VECS[0].exp);
      @(negedge clk);
      check("R8 latency update", addr_o, VECS[2].exp);

      // R8: reset in mid-run clears the output
      rst_n = 1'b0;
      @(negedge clk);
      check("R8 mid reset", addr_o, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 after reset", addr_o, VECS[2].exp);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule